// File: doc/BRIEF.md
# SEC-DED ECC Syndrome Decoder

This block guards a 64-bit data word with an 8-bit check byte. Every data bit owns a distinct 8-bit check code of odd weight. The check byte of a word is the even-parity combination, a bitwise XOR, of the codes of all data bits that are set. When a word and its stored check byte come back from memory, the block recomputes the check byte from the data and XORs it with the stored one to form a syndrome. It then sorts the syndrome into an error class.

If the syndrome equals one data bit's code, that bit is inverted. A syndrome with a single set bit points at the stored check byte itself, so the data is left alone and nothing is flagged. Other nonzero patterns are flagged as uncorrectable and the word passes through unchanged. A second field gives the kind of uncorrectable error: a double-bit error, a 4-bit error confined to a nibble, a 3-bit error confined to a nibble, or a wider pattern.

The decode path is combinational and ends in one output register. A result appears one clock after its input strobe. The recalculated check byte is also an output, so the same logic can produce check bytes for words that are about to be written. Widths are parameters, and the code table is computed at elaboration.

Top module: `ecc_sec_decoder`

## Requirements
- R1: Code table. Data bit 0 has the code 0x13, bit 2 has 0x43 and bit 6 has 0x0D. Every other data bit, taken in ascending bit order, gets the next 8-bit value of weight 3 or 5 in ascending numeric order, skipping 0x0D, 0x13 and 0x43. Bit 1 therefore gets 0x07, bit 3 gets 0x0B and bit 4 gets 0x0E.
- R2: `o_ecc_calc` is the XOR of the codes of all set bits of the received `i_data`, taken before any correction. Data 0x45 gives 0x5D.
- R3: `o_syndrome` equals `o_ecc_calc` XOR the received `i_ecc`.
- R4: A zero syndrome gives class 0 (none), and `o_data` equals `i_data`.
- R5: A syndrome with one set bit gives class 1 (check-bit error), and `o_data` equals `i_data`.
- R6: A syndrome equal to the code of data bit k gives class 2 (corrected), and `o_data` is `i_data` with bit k inverted. Data 0x45 with check byte 0x1E gives 0x41.
- R7: A syndrome with two set bits gives class 3 (uncorrectable) with kind 1 (double), and the data passes through unchanged.
- R8: A syndrome with four set bits gives class 3 with kind 2 (nibble quad), and the data passes through unchanged.
- R9: A syndrome with three or five set bits that matches no code gives class 3 with kind 3 (nibble triple), and the data passes through unchanged.
- R10: A syndrome with six or more set bits gives class 3 with kind 0 (wide). `o_ukind` is 0 whenever the class is not 3.
- R11: Results appear on the outputs one clock after a cycle with `i_valid` high, and `o_valid` is high in exactly those cycles. While `i_valid` is low, every data output holds its value.
- R12: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| i_valid | input | 1 | Received word and check byte are present |
| i_data | input | 64 | Data word as read from memory |
| i_ecc | input | 8 | Check byte as read from memory |
| o_valid | output | 1 | Result strobe, one cycle after `i_valid` |
| o_data | output | 64 | Corrected or passed-through data |
| o_ecc_calc | output | 8 | Check byte recomputed from the received data |
| o_syndrome | output | 8 | Recomputed XOR received check byte |
| o_class | output | 2 | 0 none, 1 check-bit, 2 corrected, 3 uncorrectable |
| o_ukind | output | 2 | For class 3: 0 wide, 1 double, 2 nibble quad, 3 nibble triple |

## Verification
A correction and a check-byte recomputation happen in the same cycle. The recomputed byte must describe the word as received, while the data output carries the repaired word. The bench provokes this by flipping each of the 64 data bits in turn under the check byte of the original word. It then requires three things together: `o_ecc_calc` equals the code sum of the damaged word, `o_data` equals the original word, and the class is 2. The full 256-value sweep of received check bytes over several data words also puts every classification branch on the same cycle as a nonzero recomputation.

// File: rtl/ecc_sec_pkg.sv
package ecc_sec_pkg;

   localparam int unsigned MAX_DATA_W = 128;
   localparam int unsigned MAX_CHK_W  = 16;

   typedef enum logic [1:0] {
      CLS_NONE   = 2'd0,
      CLS_CHECK  = 2'd1,
      CLS_FIXED  = 2'd2,
      CLS_UNCORR = 2'd3
   } ecc_class_e;

   typedef enum logic [1:0] {
      UK_WIDE       = 2'd0,
      UK_DOUBLE     = 2'd1,
      UK_NIB_QUAD   = 2'd2,
      UK_NIB_TRIPLE = 2'd3
   } ecc_ukind_e;

   // number of set bits in the low w bits of v
   function automatic int unsigned bit_weight(input int unsigned v, input int unsigned w);
      int unsigned n;
      n = 0;
      for (int unsigned i = 0; i < w; i++) n += (v >> i) & 32'd1;
      return n;
   endfunction

   // data-bit slots that carry fixed codes in the anchored variant
   function automatic bit is_anchor_slot(input int unsigned k);
      return (k == 0) || (k == 2) || (k == 6);
   endfunction

   function automatic bit is_anchor_value(input int unsigned v);
      return (v == 32'h13) || (v == 32'h43) || (v == 32'h0D);
   endfunction

   // how many odd-weight codes (weight 3 or 5) exist in w bits
   function automatic int unsigned odd_code_count(input int unsigned w);
      int unsigned c3;
      int unsigned c5;
      c3 = (w >= 3) ? (w * (w - 1) * (w - 2)) / 6 : 0;
      c5 = (w >= 5) ? (w * (w - 1) * (w - 2) * (w - 3) * (w - 4)) / 120 : 0;
      return c3 + c5;
   endfunction

   // flat table, entry k at [k*MAX_CHK_W +: MAX_CHK_W]
   function automatic logic [MAX_DATA_W*MAX_CHK_W-1:0] build_code_table(
      input int unsigned data_w,
      input int unsigned chk_w,
      input bit          anchored
   );
      logic [MAX_DATA_W*MAX_CHK_W-1:0] t;
      int unsigned nxt;
      int unsigned w;
      t   = '0;
      nxt = 0;
      if (anchored) begin
         t[0*MAX_CHK_W +: MAX_CHK_W] = MAX_CHK_W'(32'h13);
         t[2*MAX_CHK_W +: MAX_CHK_W] = MAX_CHK_W'(32'h43);
         t[6*MAX_CHK_W +: MAX_CHK_W] = MAX_CHK_W'(32'h0D);
      end
      for (int unsigned v = 0; v < (32'd1 << chk_w); v++) begin
         w = bit_weight(v, chk_w);
         if ((w == 3 || w == 5) && !(anchored && is_anchor_value(v))) begin
            if (anchored && is_anchor_slot(nxt)) nxt++;
            if (nxt < data_w && nxt < MAX_DATA_W)
               t[nxt*MAX_CHK_W +: MAX_CHK_W] = MAX_CHK_W'(v);
            nxt++;
         end
      end
      return t;
   endfunction

endpackage

// File: rtl/ecc_code_gen.sv
module ecc_code_gen #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8,
   parameter bit          ANCHOR = 1'b1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);
   import ecc_sec_pkg::*;

   localparam logic [MAX_DATA_W*MAX_CHK_W-1:0] TBL =
      build_code_table(DATA_W, CHK_W, ANCHOR);

   // one XOR tree per check bit over the data bits whose code has that bit set
   for (genvar c = 0; c < CHK_W; c++) begin : g_col
      logic [DATA_W-1:0] taps;
      for (genvar d = 0; d < DATA_W; d++) begin : g_tap
         assign taps[d] = data[d] & TBL[d*MAX_CHK_W + c];
      end
      assign chk[c] = ^taps;
   end

endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8,
   parameter bit          ANCHOR = 1'b1
) (
   input  logic [CHK_W-1:0]         syn,
   output ecc_sec_pkg::ecc_class_e  cls,
   output ecc_sec_pkg::ecc_ukind_e  kind,
   output logic [DATA_W-1:0]        flip
);
   import ecc_sec_pkg::*;

   localparam logic [MAX_DATA_W*MAX_CHK_W-1:0] TBL =
      build_code_table(DATA_W, CHK_W, ANCHOR);
   localparam int unsigned WT_W = $clog2(CHK_W + 1);

   logic [DATA_W-1:0] hit;
   logic [WT_W-1:0]   wt;
   logic              matched;

   // parallel comparators, one per data bit
   for (genvar d = 0; d < DATA_W; d++) begin : g_cmp
      localparam logic [CHK_W-1:0] CODE = TBL[d*MAX_CHK_W +: CHK_W];
      assign hit[d] = (syn == CODE);
   end

   assign matched = |hit;

   always_comb begin
      wt = '0;
      for (int i = 0; i < int'(CHK_W); i++) wt = wt + WT_W'(syn[i]);
   end

   always_comb begin
      cls  = CLS_UNCORR;
      kind = UK_WIDE;
      if (wt == WT_W'(0)) begin
         cls = CLS_NONE;
      end else if (wt == WT_W'(1)) begin
         cls = CLS_CHECK;
      end else if (matched) begin
         cls = CLS_FIXED;
      end else if (wt == WT_W'(2)) begin
         kind = UK_DOUBLE;
      end else if (wt == WT_W'(4)) begin
         kind = UK_NIB_QUAD;
      end else if (wt == WT_W'(3) || wt == WT_W'(5)) begin
         kind = UK_NIB_TRIPLE;
      end
   end

   assign flip = (cls == CLS_FIXED) ? hit : '0;

endmodule

// File: rtl/ecc_data_fix.sv
module ecc_data_fix #(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [DATA_W-1:0] flip,
   output logic [DATA_W-1:0] fixed
);
   for (genvar d = 0; d < DATA_W; d++) begin : g_bit
      assign fixed[d] = raw[d] ^ flip[d];
   end
endmodule

// File: rtl/ecc_sec_decoder.sv
module ecc_sec_decoder #(
   parameter int unsigned DATA_W       = 64,
   parameter int unsigned CHK_W        = 8,
   parameter bit          ANCHOR_CODES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_valid,
   input  logic [DATA_W-1:0] i_data,
   input  logic [CHK_W-1:0]  i_ecc,
   output logic              o_valid,
   output logic [DATA_W-1:0] o_data,
   output logic [CHK_W-1:0]  o_ecc_calc,
   output logic [CHK_W-1:0]  o_syndrome,
   output logic [1:0]        o_class,
   output logic [1:0]        o_ukind
);
   import ecc_sec_pkg::*;

   // elaboration-time parameter checks
   if (CHK_W < 5 || CHK_W > MAX_CHK_W) begin : g_bad_chk
      $error("ecc_sec_decoder: CHK_W out of range");
   end
   if (DATA_W < 1 || DATA_W > MAX_DATA_W) begin : g_bad_data
      $error("ecc_sec_decoder: DATA_W out of range");
   end
   if (odd_code_count(CHK_W) < DATA_W) begin : g_bad_space
      $error("ecc_sec_decoder: too few odd-weight codes for DATA_W");
   end
   if (ANCHOR_CODES && (CHK_W != 8 || DATA_W < 7)) begin : g_bad_anchor
      $error("ecc_sec_decoder: anchored codes need CHK_W=8 and DATA_W>=7");
   end

   logic [CHK_W-1:0]  calc_c;
   logic [CHK_W-1:0]  syn_c;
   ecc_class_e        cls_c;
   ecc_ukind_e        kind_c;
   logic [DATA_W-1:0] flip_c;
   logic [DATA_W-1:0] fixed_c;

   ecc_code_gen #(
      .DATA_W (DATA_W),
      .CHK_W  (CHK_W),
      .ANCHOR (ANCHOR_CODES)
   ) u_gen (
      .data (i_data),
      .chk  (calc_c)
   );

   assign syn_c = calc_c ^ i_ecc;

   ecc_syn_classify #(
      .DATA_W (DATA_W),
      .CHK_W  (CHK_W),
      .ANCHOR (ANCHOR_CODES)
   ) u_cls (
      .syn  (syn_c),
      .cls  (cls_c),
      .kind (kind_c),
      .flip (flip_c)
   );

   ecc_data_fix #(
      .DATA_W (DATA_W)
   ) u_fix (
      .raw   (i_data),
      .flip  (flip_c),
      .fixed (fixed_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid    <= 1'b0;
         o_data     <= '0;
         o_ecc_calc <= '0;
         o_syndrome <= '0;
         o_class    <= '0;
         o_ukind    <= '0;
      end else begin
         o_valid <= i_valid;
         if (i_valid) begin
            o_data     <= fixed_c;
            o_ecc_calc <= calc_c;
            o_syndrome <= syn_c;
            o_class    <= cls_c;
            o_ukind    <= (cls_c == CLS_UNCORR) ? kind_c : UK_WIDE;
         end
      end
   end

endmodule

// File: rtl/ecc_sec_decoder_chk.sv
module ecc_sec_decoder_chk #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned CHK_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              i_valid,
   input logic [DATA_W-1:0] i_data,
   input logic [CHK_W-1:0]  i_ecc,
   input logic              o_valid,
   input logic [DATA_W-1:0] o_data,
   input logic [CHK_W-1:0]  o_ecc_calc,
   input logic [CHK_W-1:0]  o_syndrome,
   input logic [1:0]        o_class,
   input logic [1:0]        o_ukind
);

   a_r11_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      i_valid |=> o_valid);

   a_r11_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !i_valid |=> !o_valid);

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !i_valid |=> ($stable(o_data) && $stable(o_syndrome) && $stable(o_class)));

   a_r3_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
      i_valid |=> (o_syndrome == (o_ecc_calc ^ $past(i_ecc))));

   a_r4_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_class == 2'd0) |-> (o_syndrome == '0));

   a_r5_check_single: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_class == 2'd1) |-> ($countones(o_syndrome) == 1));

   a_r6_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid ##1 o_class == 2'd2) |-> ($countones(o_data ^ $past(i_data)) == 1));

   a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid ##1 o_class != 2'd2) |-> (o_data == $past(i_data)));

   a_r7_double: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && $countones(o_syndrome) == 2) |-> (o_class == 2'd3 && o_ukind == 2'd1));

   a_r8_quad: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && $countones(o_syndrome) == 4) |-> (o_class == 2'd3 && o_ukind == 2'd2));

   a_r10_wide: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && $countones(o_syndrome) >= 6) |-> (o_class == 2'd3 && o_ukind == 2'd0));

   a_r10_kind_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_class != 2'd3) |-> (o_ukind == 2'd0));

endmodule

bind ecc_sec_decoder ecc_sec_decoder_chk #(
   .DATA_W (DATA_W),
   .CHK_W  (CHK_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .i_valid    (i_valid),
   .i_data     (i_data),
   .i_ecc      (i_ecc),
   .o_valid    (o_valid),
   .o_data     (o_data),
   .o_ecc_calc (o_ecc_calc),
   .o_syndrome (o_syndrome),
   .o_class    (o_class),
   .o_ukind    (o_ukind)
);

// File: tb/ecc_sec_decoder_bench.sv
`timescale 1ns/1ps
module ecc_sec_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_valid = 1'b0;
   logic [63:0] i_data = '0;
   logic [7:0]  i_ecc = '0;
   logic        o_valid;
   logic [63:0] o_data;
   logic [7:0]  o_ecc_calc;
   logic [7:0]  o_syndrome;
   logic [1:0]  o_class;
   logic [1:0]  o_ukind;

   int checks = 0;
   int failures = 0;
   logic [7:0] tbl [64];

   always #4 clk = ~clk;

   ecc_sec_decoder u_ecc_sec_decoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .i_valid    (i_valid),
      .i_data     (i_data),
      .i_ecc      (i_ecc),
      .o_valid    (o_valid),
      .o_data     (o_data),
      .o_ecc_calc (o_ecc_calc),
      .o_syndrome (o_syndrome),
      .o_class    (o_class),
      .o_ukind    (o_ukind)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // R1 table rule
   function automatic void build_tbl();
      int nxt = 0;
      for (int k = 0; k < 64; k++) tbl[k] = 8'h00;
      tbl[0] = 8'h13; tbl[2] = 8'h43; tbl[6] = 8'h0D;
      for (int v = 0; v < 256; v++) begin
         int w = $countones(v[7:0]);
         if ((w == 3 || w == 5) && v != 8'h13 && v != 8'h43 && v != 8'h0D) begin
            while (nxt == 0 || nxt == 2 || nxt == 6) nxt++;
            if (nxt < 64) tbl[nxt] = v[7:0];
            nxt++;
         end
      end
   endfunction

   function automatic logic [7:0] calc_of(input logic [63:0] d);
      logic [7:0] e = 8'h00;
      for (int k = 0; k < 64; k++) if (d[k]) e ^= tbl[k];
      return e;
   endfunction

   task automatic drive(input logic v, input logic [63:0] d, input logic [7:0] e);
      i_valid = v; i_data = d; i_ecc = e;
      @(negedge clk);
   endtask

   // drive one word and judge every output against the requirement rules
   task automatic run_word(input logic [63:0] d, input logic [7:0] e);
      logic [7:0]  c   = calc_of(d);
      logic [7:0]  s   = c ^ e;
      int          w   = $countones(s);
      int          hit = -1;
      logic [1:0]  ec;
      logic [1:0]  ek  = 2'd0;
      logic [63:0] ed  = d;
      string       rq;
      for (int k = 0; k < 64; k++) if (tbl[k] == s) hit = k;
      if (w == 0)            begin ec = 2'd0; rq = "R4"; end
      else if (w == 1)       begin ec = 2'd1; rq = "R5"; end
      else if (hit >= 0)     begin ec = 2'd2; rq = "R6"; ed = d ^ (64'd1 << hit); end
      else if (w == 2)       begin ec = 2'd3; ek = 2'd1; rq = "R7"; end
      else if (w == 4)       begin ec = 2'd3; ek = 2'd2; rq = "R8"; end
      else if (w == 3 || w == 5) begin ec = 2'd3; ek = 2'd3; rq = "R9"; end
      else                   begin ec = 2'd3; ek = 2'd0; rq = "R10"; end
      drive(1'b1, d, e);
      check(o_valid == 1'b1, "R11", "valid", 64'(o_valid), 64'd1);
      check(o_ecc_calc == c, "R2", "ecc_calc", 64'(o_ecc_calc), 64'(c));
      check(o_syndrome == s, "R3", "syndrome", 64'(o_syndrome), 64'(s));
      check(o_class == ec, rq, "class", 64'(o_class), 64'(ec));
      check(o_ukind == ek, rq, "kind", 64'(o_ukind), 64'(ek));
      check(o_data == ed, rq, "data", o_data, ed);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [63:0] pats [6];
      logic [63:0] held;
      logic [7:0]  held_syn;
      build_tbl();
      pats[0] = 64'h45;
      pats[1] = 64'h0;
      pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[3] = 64'hA5A5_5A5A_F00F_0FF0;
      pats[4] = 64'h0123_4567_89AB_CDEF;
      pats[5] = 64'h8000_0000_0000_0001;

      // R12: reset state
      repeat (3) @(negedge clk);
      check(o_valid == 1'b0, "R12", "valid", 64'(o_valid), 64'd0);
      check(o_data == 64'd0, "R12", "data", o_data, 64'd0);
      check({o_ecc_calc, o_syndrome, o_class, o_ukind} == '0, "R12", "misc",
            64'({o_ecc_calc, o_syndrome, o_class, o_ukind}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: anchored and first derived codes via one-hot words
      check(tbl[1] == 8'h07 && tbl[3] == 8'h0B && tbl[4] == 8'h0E, "R1", "bench table",
            64'({tbl[1], tbl[3], tbl[4]}), 64'h070B0E);
      for (int k = 0; k < 64; k++) begin
         drive(1'b1, 64'd1 << k, 8'h00);
         check(o_ecc_calc == tbl[k], "R1", "code", 64'(o_ecc_calc), 64'(tbl[k]));
      end

      // R2 and R6 worked examples
      drive(1'b1, 64'h45, 8'h5D);
      check(o_ecc_calc == 8'h5D, "R2", "0x45 ecc", 64'(o_ecc_calc), 64'h5D);
      check(o_class == 2'd0, "R4", "clean class", 64'(o_class), 64'd0);
      drive(1'b1, 64'h45, 8'h1E);
      check(o_data == 64'h41, "R6", "0x45 fixed", o_data, 64'h41);
      check(o_syndrome == 8'h43, "R6", "0x45 syn", 64'(o_syndrome), 64'h43);

      // R3..R10: every received check byte over several words
      foreach (pats[p]) begin
         for (int e = 0; e < 256; e++) run_word(pats[p], e[7:0]);
      end

      // R2/R6: single data-bit damage under the clean check byte
      for (int k = 0; k < 64; k++) begin
         logic [63:0] good = pats[4];
         logic [63:0] bad  = good ^ (64'd1 << k);
         drive(1'b1, bad, calc_of(good));
         check(o_ecc_calc == calc_of(bad), "R2", "raw ecc", 64'(o_ecc_calc), 64'(calc_of(bad)));
         check(o_data == good, "R6", "repaired", o_data, good);
         check(o_class == 2'd2, "R6", "class", 64'(o_class), 64'd2);
      end

      // R11: latency one and hold while idle
      drive(1'b0, 64'h0, 8'h0);
      check(o_valid == 1'b0, "R11", "idle valid", 64'(o_valid), 64'd0);
      drive(1'b1, 64'h45, 8'h55);
      held = o_data; held_syn = o_syndrome;
      check(o_valid == 1'b1 && o_class == 2'd1, "R11", "strobe", 64'({o_valid, o_class}), 64'b101);
      drive(1'b0, 64'hDEAD_BEEF_0000_1111, 8'hFF);
      check(o_valid == 1'b0, "R11", "drop", 64'(o_valid), 64'd0);
      check(o_data == held, "R11", "hold data", o_data, held);
      check(o_syndrome == held_syn, "R11", "hold syn", 64'(o_syndrome), 64'(held_syn));
      drive(1'b0, 64'h1234, 8'h0F);
      check(o_data == held && o_class == 2'd1, "R11", "hold 2", o_data, held);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule